// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block holds the tag side of a direct-mapped cache. Every entry keeps a 14-bit tag and two status bits, valid and dirty. An index selects one entry. The block compares that entry's stored tag with a probe tag on the same input bus and drives a hit flag. The compare path and both read paths are purely combinational from the index. Tag writes and status writes are synchronous, and each has its own active-low enable.

A mode input sets how the status bits are used. In dedicated mode the stored valid bit qualifies the hit. In generic mode the hit reflects only tag equality, and the status bits are plain storage for the user. A synchronous active-low clear empties the status bits of every entry on one clock edge and leaves all tags in place.

Two chip selects, separate output enables and a power-down input gate the outputs. Each output group is modelled as a data bus plus an enable line instead of a tri-state pin.

Top module: `tag_store_cmp`

## Requirements
- R1: When the block is selected with `tag_oe_n`=0 and `tag_we_n`=1, `tag_out_en` is 1 and `tag_out` shows the tag stored at `idx`. A tag write (`tag_we_n`=0 at a rising edge while selected) stores `tag_in` at `idx`.
- R2: In dedicated mode (`generic_mode`=0), `hit` is 1 only when the stored valid bit at `idx` is 1 and the stored tag equals `tag_in`.
- R3: In generic mode (`generic_mode`=1), `hit` equals tag equality alone, whatever the stored valid bit is.
- R4: `hit` is 0 in any of these cycles: a tag read (`tag_oe_n`=0 with `tag_we_n`=1), a tag write, a status write, or a clear (`clr_n`=0).
- R5: While `stat_we_n`=0 and `clr_n`=1, `valid_out`/`dirty_out` show `valid_in`/`dirty_in` directly, and the next rising edge stores them at `idx`.
- R6: A tag write leaves the status bits unchanged, and a status write leaves the tag unchanged.
- R7: `clr_n`=0 at a rising edge sets valid and dirty of every entry to 0 and keeps every stored tag. While `clr_n`=0, the status outputs read 0.
- R8: When a clear and a status write happen at the same edge, the clear wins and the entry ends with both status bits at 0.
- R9: The block is selected only when `sel_n`=0 and `sel`=1. When it is not selected, `tag_out_en`, `stat_out_en` and `hit_en` are 0, and no tag or status write takes effect.
- R10: `tag_oe_n` gates only `tag_out_en`, and `stat_oe_n` gates only `stat_out_en`. `hit_en` follows selection alone.
- R11: `pdn_n`=0 turns off all three output enables and blocks tag and status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clear on rising edge |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| pdn_n | input | 1 | Power-down, active low, asynchronous |
| generic_mode | input | 1 | 0 = valid qualifies hit, 1 = status is user storage |
| clr_n | input | 1 | Synchronous clear of all status bits, active low |
| idx | input | IDX_W | Entry index |
| tag_in | input | TAG_W | Probe tag and tag write data |
| tag_we_n | input | 1 | Tag write enable, active low |
| stat_we_n | input | 1 | Status write enable, active low |
| valid_in | input | 1 | Valid bit write data |
| dirty_in | input | 1 | Dirty bit write data |
| tag_oe_n | input | 1 | Tag output enable, active low |
| stat_oe_n | input | 1 | Status output enable, active low |
| tag_out | output | TAG_W | Stored tag at idx |
| tag_out_en | output | 1 | Tag output driven |
| valid_out | output | 1 | Valid bit read or write-through |
| dirty_out | output | 1 | Dirty bit read or write-through |
| stat_out_en | output | 1 | Status outputs driven |
| hit | output | 1 | Tag hit flag |
| hit_en | output | 1 | Hit output driven |

## Verification
The bench goes after the case where the stored valid bit is 0 and the tags are equal. A design that ignored the mode pin would report a hit in dedicated mode, or would miss one in generic mode. It also stacks a clear on top of a status write: a wrong priority would leave the written valid bit set. After a clear it reads the tags back, because a clear that reached the tag array would wipe them. Writes attempted while deselected or powered down are followed by reads, so that a missing gate shows up as changed data.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef struct packed {
      logic valid;
      logic dirty;
   } stat_t;

   localparam int unsigned MAX_IDX_W = 14;
endpackage

// File: rtl/tsc_tag_array.sv
module tsc_tag_array #(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned TAG_W = 14
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] din,
   output logic [TAG_W-1:0] rd
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [TAG_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= din;
   end

   assign rd = mem[idx];

   // R1: a written tag is present at its index one edge later
   p_tag_wr_r1: assert property (@(posedge clk) disable iff (!we && 1'b0)
      we |=> (mem[$past(idx)] == $past(din)));
endmodule

// File: rtl/tsc_status_bank.sv
module tsc_status_bank
   import tsc_pkg::*;
#(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  stat_t            wdata,
   output stat_t            rd
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] v_q;
   logic [DEPTH-1:0] d_q;

   // per-entry flops so that the clear reaches every entry on one edge
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!clr_n) begin
            v_q[e] <= 1'b0;
            d_q[e] <= 1'b0;
         end else if (we && idx == IDX_W'(e)) begin
            v_q[e] <= wdata.valid;
            d_q[e] <= wdata.dirty;
         end
      end
   end

   assign rd.valid = v_q[idx];
   assign rd.dirty = d_q[idx];

   // R7 / R8: a clear empties every status bit, even with a write at the same edge
   p_clear_all_r7: assert property (@(posedge clk) disable iff (1'b0)
      !clr_n |=> (v_q == '0 && d_q == '0));

   // R5: a status write lands at its index
   p_stat_wr_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (we && clr_n) |=> (v_q[$past(idx)] == $past(wdata.valid)
                         && d_q[$past(idx)] == $past(wdata.dirty)));
endmodule

// File: rtl/tsc_match_unit.sv
module tsc_match_unit #(
   parameter int unsigned TAG_W   = 14,
   parameter bit          XOR_CMP = 1'b1
) (
   input  logic [TAG_W-1:0] stored,
   input  logic [TAG_W-1:0] probe,
   input  logic             valid,
   input  logic             generic_mode,
   input  logic             block,
   output logic             hit
);
   logic eq;

   if (XOR_CMP) begin : g_xor
      logic [TAG_W-1:0] diff;
      assign diff = stored ^ probe;
      assign eq   = ~|diff;
   end else begin : g_direct
      assign eq = (stored == probe);
   end

   assign hit = !block && eq && (generic_mode || valid);

   always_comb begin
      // R2: dedicated mode never hits on an invalid entry
      if (!generic_mode && !valid) p_invalid_miss_r2: assert (!hit);
      // R4: busy cycles force the hit low
      if (block) p_busy_low_r4: assert (!hit);
      // R3: generic mode with equal tags and no busy cycle always hits
      if (generic_mode && !block && stored == probe) p_generic_hit_r3: assert (hit);
   end
endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
   import tsc_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned TAG_W   = 14,
   parameter bit          XOR_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             sel_n,
   input  logic             sel,
   input  logic             pdn_n,
   input  logic             generic_mode,
   input  logic             clr_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] tag_in,
   input  logic             tag_we_n,
   input  logic             stat_we_n,
   input  logic             valid_in,
   input  logic             dirty_in,
   input  logic             tag_oe_n,
   input  logic             stat_oe_n,
   output logic [TAG_W-1:0] tag_out,
   output logic             tag_out_en,
   output logic             valid_out,
   output logic             dirty_out,
   output logic             stat_out_en,
   output logic             hit,
   output logic             hit_en
);
   if (IDX_W < 1 || IDX_W > MAX_IDX_W) begin : g_bad_idx
      $error("tag_store_cmp: IDX_W out of range");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("tag_store_cmp: TAG_W must be positive");
   end

   logic  chip_on;
   logic  tag_wr, stat_wr, tag_rd_cyc, busy;
   logic [TAG_W-1:0] tag_rd;
   stat_t stat_rd, stat_wd;

   assign chip_on    = !sel_n && sel && pdn_n;
   assign tag_wr     = chip_on && !tag_we_n;
   assign stat_wr    = chip_on && !stat_we_n;
   assign tag_rd_cyc = !tag_oe_n && tag_we_n;
   assign busy       = tag_rd_cyc || !tag_we_n || !stat_we_n || !clr_n;
   assign stat_wd    = '{valid: valid_in, dirty: dirty_in};

   tsc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .we(tag_wr), .idx(idx), .din(tag_in), .rd(tag_rd)
   );

   tsc_status_bank #(.IDX_W(IDX_W)) u_stat (
      .clk(clk), .clr_n(clr_n), .we(stat_wr), .idx(idx),
      .wdata(stat_wd), .rd(stat_rd)
   );

   tsc_match_unit #(.TAG_W(TAG_W), .XOR_CMP(XOR_CMP)) u_match (
      .stored(tag_rd), .probe(tag_in), .valid(stat_rd.valid),
      .generic_mode(generic_mode), .block(busy), .hit(hit)
   );

   assign tag_out     = tag_rd;
   assign tag_out_en  = chip_on && tag_rd_cyc;
   assign stat_out_en = chip_on && !stat_oe_n;
   assign hit_en      = chip_on;

   always_comb begin
      if (!clr_n) begin
         valid_out = 1'b0;
         dirty_out = 1'b0;
      end else if (!stat_we_n) begin
         valid_out = valid_in;
         dirty_out = dirty_in;
      end else begin
         valid_out = stat_rd.valid;
         dirty_out = stat_rd.dirty;
      end
   end

   always_comb begin
      // R9: deselection turns every output enable off
      if (sel_n || !sel) p_desel_off_r9: assert (!tag_out_en && !stat_out_en && !hit_en);
      // R11: power-down turns every output enable off
      if (!pdn_n) p_pdn_off_r11: assert (!tag_out_en && !stat_out_en && !hit_en);
   end

   // R6: a tag write with no status write leaves the addressed status bits alone
   p_tag_keeps_stat_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (tag_wr && !stat_wr && clr_n) |=> (stat_rd.valid == $past(stat_rd.valid)
                                          || idx != $past(idx)));
endmodule

// File: tb/sim_tag_store_cmp.sv
module sim_tag_store_cmp;
   localparam int IDX_W = 8;
   localparam int TAG_W = 14;
   localparam int DEPTH = 1 << IDX_W;

   logic clk = 1'b0;
   logic sel_n, sel, pdn_n, generic_mode, clr_n;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag_in;
   logic tag_we_n, stat_we_n, valid_in, dirty_in, tag_oe_n, stat_oe_n;
   logic [TAG_W-1:0] tag_out;
   logic tag_out_en, valid_out, dirty_out, stat_out_en, hit, hit_en;

   int tests = 0;
   int fails = 0;

   logic [TAG_W-1:0] m_tag [DEPTH];
   logic m_v [DEPTH];
   logic m_d [DEPTH];

   always #4 clk = ~clk;

   tag_store_cmp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (.*);

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_hit(input bit on, input logic [IDX_W-1:0] i);
      bit busy;
      busy = (!tag_oe_n && tag_we_n) || !tag_we_n || !stat_we_n || !clr_n;
      return on && !busy && (m_tag[i] == tag_in) && (generic_mode || m_v[i]);
   endfunction

   // drive at the falling edge, check before the rising edge, then update the model
   task automatic op(input bit sn, input bit s, input bit pd, input bit gm, input bit cn,
                     input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t,
                     input bit twn, input bit swn, input bit vi, input bit di,
                     input bit toe, input bit soe, input string req);
      bit on, ev, ed;
      @(negedge clk);
      sel_n = sn; sel = s; pdn_n = pd; generic_mode = gm; clr_n = cn;
      idx = i; tag_in = t; tag_we_n = twn; stat_we_n = swn;
      valid_in = vi; dirty_in = di; tag_oe_n = toe; stat_oe_n = soe;
      #2;
      on = !sn && s && pd;
      chk(on ? "R10" : (pd ? "R9" : "R11"), "hit_en", int'(hit_en), int'(on));
      chk(req, "hit", int'(hit_en && hit), int'(exp_hit(on, i)));
      chk(on ? "R10" : "R9", "tag_out_en", int'(tag_out_en), int'(on && !toe && twn));
      if (on && !toe && twn) chk("R1", "tag_out", int'(tag_out), int'(m_tag[i]));
      chk(on ? "R10" : "R11", "stat_out_en", int'(stat_out_en), int'(on && !soe));
      if (on && !soe) begin
         ev = !cn ? 1'b0 : (!swn ? vi : m_v[i]);
         ed = !cn ? 1'b0 : (!swn ? di : m_d[i]);
         chk(!cn ? "R7" : (!swn ? "R5" : "R6"), "valid_out", int'(valid_out), int'(ev));
         chk(!cn ? "R7" : (!swn ? "R5" : "R6"), "dirty_out", int'(dirty_out), int'(ed));
      end
      if (!cn) begin
         for (int k = 0; k < DEPTH; k++) begin m_v[k] = 1'b0; m_d[k] = 1'b0; end
      end else if (on && !swn) begin
         m_v[i] = vi; m_d[i] = di;
      end
      if (on && !twn) m_tag[i] = t;
      @(posedge clk);
   endtask

   // read-only probe: tag read plus status read, no writes
   task automatic rd(input logic [IDX_W-1:0] i, input string req);
      op(0, 1, 1, 0, 1, i, '0, 1, 1, 0, 0, 0, 0, req);
   endtask

   initial begin : wdog
      #1500000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      sel_n = 1; sel = 0; pdn_n = 1; generic_mode = 0; clr_n = 1; idx = '0; tag_in = '0;
      tag_we_n = 1; stat_we_n = 1; valid_in = 0; dirty_in = 0; tag_oe_n = 1; stat_oe_n = 1;
      // initial clear, then fill every tag
      op(1, 0, 1, 0, 0, '0, '0, 1, 1, 0, 0, 1, 1, "R7");
      for (int k = 0; k < DEPTH; k++)
         op(0, 1, 1, 0, 1, IDX_W'(k), TAG_W'(k * 37 + 5), 0, 1, 0, 0, 1, 1, "R4");
      // reset state of status: all zero (R7)
      rd(8'd3, "R7");
      // R2: equal tag but invalid -> miss in dedicated mode
      op(0, 1, 1, 0, 1, 8'd3, TAG_W'(3 * 37 + 5), 1, 1, 0, 0, 1, 0, "R2");
      // R3: same probe in generic mode -> hit
      op(0, 1, 1, 1, 1, 8'd3, TAG_W'(3 * 37 + 5), 1, 1, 0, 0, 1, 0, "R3");
      // R5: status write with write-through, R4 hit low
      op(0, 1, 1, 0, 1, 8'd3, TAG_W'(3 * 37 + 5), 1, 0, 1, 1, 1, 0, "R4");
      // R2: now valid and equal -> hit; R6: tag unchanged by status write
      op(0, 1, 1, 0, 1, 8'd3, TAG_W'(3 * 37 + 5), 1, 1, 0, 0, 1, 0, "R2");
      rd(8'd3, "R6");
      // R6: tag write keeps status
      op(0, 1, 1, 0, 1, 8'd3, 14'h2abc, 0, 1, 0, 0, 1, 0, "R6");
      rd(8'd3, "R6");
      // R8: clear together with status write -> cleared
      op(0, 1, 1, 0, 1, 8'd9, '0, 1, 0, 1, 1, 1, 0, "R5");
      op(0, 1, 1, 0, 0, 8'd9, '0, 1, 0, 1, 1, 1, 0, "R8");
      rd(8'd9, "R8");
      // R7: tags survive the clear
      rd(8'd3, "R7");
      // R9: deselected writes have no effect
      op(1, 1, 1, 0, 1, 8'd20, 14'h1111, 0, 0, 1, 1, 0, 0, "R9");
      op(0, 0, 1, 0, 1, 8'd20, 14'h1111, 0, 0, 1, 1, 0, 0, "R9");
      rd(8'd20, "R9");
      // R11: powered-down writes have no effect
      op(0, 1, 0, 0, 1, 8'd21, 14'h2222, 0, 0, 1, 1, 0, 0, "R11");
      rd(8'd21, "R11");
      // R10: status enable alone, tag enable alone
      op(0, 1, 1, 0, 1, 8'd3, '0, 1, 1, 0, 0, 1, 0, "R10");
      op(0, 1, 1, 0, 1, 8'd3, '0, 1, 1, 0, 0, 0, 1, "R10");
      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic [IDX_W-1:0] ri;
         logic [TAG_W-1:0] rt;
         bit rs, rsh, rpd, rcn, rtw, rsw, rtoe;
         ri   = IDX_W'($urandom_range(0, 15));
         rt   = ($urandom_range(0, 1) == 1) ? m_tag[ri] : TAG_W'($urandom);
         rs   = ($urandom_range(0, 15) == 0);
         rsh  = ($urandom_range(0, 15) != 0);
         rpd  = ($urandom_range(0, 15) != 0);
         rcn  = ($urandom_range(0, 63) != 0);
         rtw  = ($urandom_range(0, 7) != 0);
         rsw  = ($urandom_range(0, 3) != 0);
         rtoe = ($urandom_range(0, 3) != 0);
         op(rs, rsh, rpd, bit'($urandom_range(0, 1)), rcn, ri, rt, rtw, rsw,
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), rtoe,
            bit'($urandom_range(0, 3) == 0), "R2");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule